// File: doc/BRIEF.md
# Error Event Code Queue

This block holds a short history of signed 16-bit error and event codes in arrival order. Producers offer a code with a one-cycle push strobe. A reader always sees the oldest stored code at the output, and pulses a pop strobe to remove it. A level output tells the status summary logic whether any code is waiting.

The queue holds twenty entries. A push that arrives while the queue is full does not displace older entries. Instead, the youngest stored entry is rewritten once with the reserved overflow code -350, and the incoming code is lost. Later pushes that arrive while the queue stays full are discarded without any change. When the queue is empty, the output shows 0, which is the code for "no error". A clear strobe and the power-up reset both empty the queue.

Top module: `errq_top`

## Requirements
- R1: The queue holds up to 20 codes. Twenty pushes into an empty queue with no pops are all kept and read back.
- R2: Codes leave in arrival order. `head_code_o` shows the oldest stored code, and a pop removes exactly that code on the clock edge.
- R3: A push while 20 codes are stored and no pop is accepted in the same cycle rewrites the youngest stored code to -350 (0xFEA2). The pushed code is discarded and the occupancy stays at 20.
- R4: An overflow leaves the 19 older codes and their order unchanged.
- R5: While the youngest stored code is already -350 and the queue is full, further pushes are dropped. They change neither the contents nor the occupancy.
- R6: With the queue empty, `head_code_o` reads 0. A pop on an empty queue has no effect.
- R7: Reset, and a `clr_i` pulse on a clock edge, both empty the queue. `clr_i` wins over a push or a pop in the same cycle.
- R8: `not_empty_o` rises on the edge that stores the first code. It falls on the edge that pops the last code.
- R9: A push and a pop in the same cycle on a full queue act as a pop followed by an ordinary push. No overflow code is written.
- R10: A push and a pop in the same cycle on a partly filled queue keep the occupancy unchanged and append the new code behind the remaining ones.
- R11: Any 16-bit code, including -32768 and 32767, is returned bit-exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| clr_i | input | 1 | Clear strobe, empties the queue |
| push_vld_i | input | 1 | Push strobe for `push_code_i` |
| push_code_i | input | 16 | Signed code to store |
| pop_i | input | 1 | Removes the oldest code |
| head_code_o | output | 16 | Oldest code, or 0 when empty |
| not_empty_o | output | 1 | High while at least one code is stored |

## Verification
A wrong occupancy count shows up at the ports only late. The flag falls one pop too early or too late, or a drained queue shows 0 before the expected final code. For this reason every scenario drains the queue completely and compares each code and the flag after every pop. A misplaced overflow write shows up as a -350 in the wrong position during the drain, or as a lost older code. A marker written twice shows up as an extra entry. A head pointer that slips shows up at the very next pop as the wrong code.

// File: rtl/errq_pkg.sv
package errq_pkg;
  localparam int ERRQ_DEPTH_DEF  = 20;
  localparam int ERRQ_CODE_W_DEF = 16;
  localparam int ERRQ_OVF_CODE   = -350;

  // Outcome of a push request in one cycle
  typedef enum logic [1:0] {
    PUSH_NONE  = 2'd0,
    PUSH_STORE = 2'd1,
    PUSH_MARK  = 2'd2,
    PUSH_DROP  = 2'd3
  } push_act_e;
endpackage

// File: rtl/errq_ctrl.sv
module errq_ctrl
  import errq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push_i,
  input  logic      pop_i,
  input  logic      clr_i,
  input  logic      full_i,
  input  logic      empty_i,
  input  logic      tail_is_mark_i,
  output logic      do_pop_o,
  output push_act_e act_o
);
  logic full_push;

  always_comb begin
    do_pop_o  = pop_i && !empty_i && !clr_i;
    full_push = push_i && !clr_i && full_i && !do_pop_o;
    act_o     = PUSH_NONE;
    if (push_i && !clr_i) begin
      if (!full_push)         act_o = PUSH_STORE;
      else if (tail_is_mark_i) act_o = PUSH_DROP;
      else                    act_o = PUSH_MARK;
    end
  end

  // R6: nothing is removed from an empty queue
  p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty_i |-> !do_pop_o);
  // R7: a clear suppresses every other action
  p_clr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> (act_o == PUSH_NONE && !do_pop_o));
endmodule

// File: rtl/errq_ptrs.sv
module errq_ptrs #(
  parameter int DEPTH = 20,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             adv_tail_i,
  input  logic             adv_head_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [PTR_W-1:0] last_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == TOP_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? TOP_IDX : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (adv_tail_i) tail_q <= ptr_next(tail_q);
      if (adv_head_i) head_q <= ptr_next(head_q);
      case ({adv_tail_i, adv_head_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign last_o  = ptr_prev(tail_q);
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);

  // R1: occupancy never exceeds the depth
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R3: a full queue with a push and no pop stays full
  p_ovf_stays_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i && !clr_i) |=> full_o);
  // R7: a clear leaves the queue empty
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R9: a simultaneous push and pop on a full queue keeps it full
  p_swap_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && pop_i && !clr_i) |=> full_o);
  // R10: push and pop together on a partial queue keep the count
  p_swap_partial_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && !full_o && push_i && pop_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/errq_store.sv
module errq_store #(
  parameter int DEPTH  = 20,
  parameter int CODE_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  widx_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  head_idx_i,
  input  logic [PTR_W-1:0]  last_idx_i,
  output logic [CODE_W-1:0] head_word_o,
  output logic [CODE_W-1:0] last_word_o
);
  logic [CODE_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    slot_q[g] <= '0;
      else if (we_i && (widx_i == PTR_W'(g)))        slot_q[g] <= wdata_i;
    end
  end

  assign head_word_o = slot_q[head_idx_i];
  assign last_word_o = slot_q[last_idx_i];
endmodule

// File: rtl/errq_top.sv
module errq_top
  import errq_pkg::*;
#(
  parameter int DEPTH    = ERRQ_DEPTH_DEF,
  parameter int CODE_W   = ERRQ_CODE_W_DEF,
  parameter int OVF_CODE = ERRQ_OVF_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              push_vld_i,
  input  logic [CODE_W-1:0] push_code_i,
  input  logic              pop_i,
  output logic [CODE_W-1:0] head_code_o,
  output logic              not_empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CODE_W-1:0] OVF_BITS = CODE_W'(OVF_CODE);

  // Named internal events for the assertions
  logic              ev_pop;
  push_act_e         ev_act;
  logic              ev_store, ev_mark;
  logic [PTR_W-1:0]  head_idx, tail_idx, last_idx, widx;
  logic [CNT_W-1:0]  cnt;
  logic              full, empty, tail_is_mark, we;
  logic [CODE_W-1:0] wdata, head_word, last_word;

  assign tail_is_mark = (last_word == OVF_BITS);
  assign ev_store     = (ev_act == PUSH_STORE);
  assign ev_mark      = (ev_act == PUSH_MARK);

  errq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .push_i         (push_vld_i),
    .pop_i          (pop_i),
    .clr_i          (clr_i),
    .full_i         (full),
    .empty_i        (empty),
    .tail_is_mark_i (tail_is_mark),
    .do_pop_o       (ev_pop),
    .act_o          (ev_act)
  );

  errq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .push_i     (push_vld_i),
    .pop_i      (pop_i),
    .adv_tail_i (ev_store),
    .adv_head_i (ev_pop),
    .head_o     (head_idx),
    .tail_o     (tail_idx),
    .last_o     (last_idx),
    .cnt_o      (cnt),
    .full_o     (full),
    .empty_o    (empty)
  );

  assign we    = ev_store || ev_mark;
  assign widx  = ev_mark ? last_idx : tail_idx;
  assign wdata = ev_mark ? OVF_BITS : push_code_i;

  errq_store #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (we),
    .widx_i      (widx),
    .wdata_i     (wdata),
    .head_idx_i  (head_idx),
    .last_idx_i  (last_idx),
    .head_word_o (head_word),
    .last_word_o (last_word)
  );

  assign head_code_o = empty ? '0 : head_word;
  assign not_empty_o = !empty;

  // R3: an overflow leaves the marker in the youngest slot
  p_mark_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_act == PUSH_MARK) |=> (last_word == OVF_BITS && full));
  // R4: the oldest entry is untouched by an overflow
  p_head_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_act == PUSH_MARK) |=> $stable(head_word));
  // R5: a dropped push changes neither tail nor occupancy
  p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_act == PUSH_DROP) |=> ($stable(cnt) && $stable(tail_idx)));
  // R6: an empty queue reads as the no-error code
  p_empty_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty_o |-> (head_code_o == '0));
  // R8: popping the only entry drops the flag
  p_flag_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(1) && pop_i && !push_vld_i && !clr_i) |=> !not_empty_o);
  // R9: a push and pop together on a full queue never write the marker
  p_no_mark_on_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop_i && push_vld_i) |-> (ev_act != PUSH_MARK));
endmodule

// File: tb/test_errq_top.sv
`timescale 1ns/1ps
module test_errq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, push = 1'b0, pop = 1'b0;
  logic signed [15:0] code = '0;
  logic signed [15:0] head;
  logic ne;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  errq_top i_errq_top (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .push_vld_i(push),
    .push_code_i(code), .pop_i(pop), .head_code_o(head), .not_empty_o(ne)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle of stimulus, starting and ending at a falling edge
  task automatic cyc(input bit ps, input int c, input bit pp, input bit cl);
    push = ps; code = 16'(c); pop = pp; clr = cl;
    @(negedge clk);
    push = 0; pop = 0; clr = 0;
  endtask

  task automatic pop_expect(input string req, input int exp);
    chk(req, int'(head), exp);
    cyc(0, 0, 1, 0);
  endtask

  task automatic t_reset;
    chk("R7 reset flag", int'(ne), 0);
    chk("R6 reset head", int'(head), 0);
  endtask

  task automatic t_basic;
    cyc(1, -32768, 0, 0);
    chk("R8 flag rises", int'(ne), 1);
    cyc(1, 32767, 0, 0);
    cyc(1, 5, 0, 0);
    pop_expect("R11 min code", -32768);
    pop_expect("R11 max code", 32767);
    chk("R8 flag before last pop", int'(ne), 1);
    pop_expect("R2 order", 5);
    chk("R8 flag falls", int'(ne), 0);
    chk("R6 empty head", int'(head), 0);
  endtask

  task automatic t_empty_pop;
    cyc(0, 0, 1, 0);
    chk("R6 pop on empty flag", int'(ne), 0);
    cyc(1, 7, 0, 0);
    pop_expect("R6 pop on empty no effect", 7);
    chk("R6 empty again", int'(ne), 0);
  endtask

  task automatic t_overflow;
    for (int i = 1; i <= 20; i++) cyc(1, i, 0, 0);
    cyc(1, 999, 0, 0);
    cyc(1, 1234, 0, 0);
    cyc(1, -350, 0, 0);
    cyc(1, 4321, 0, 0);
    for (int i = 1; i <= 19; i++) pop_expect("R4 older kept", i);
    pop_expect("R3 marker in youngest slot", -350);
    chk("R5 no extra entries", int'(ne), 0);
    chk("R5 head zero after drain", int'(head), 0);
  endtask

  task automatic t_full_swap;
    for (int i = 0; i < 20; i++) cyc(1, 100 + i, 0, 0);
    chk("R1 head after 20 pushes", int'(head), 100);
    chk("R9 head before swap", int'(head), 100);
    cyc(1, 500, 1, 0);
    for (int i = 1; i < 20; i++) pop_expect("R1 full depth kept", 100 + i);
    pop_expect("R9 pushed code stored, no marker", 500);
    chk("R9 drained", int'(ne), 0);
  endtask

  task automatic t_partial_swap;
    cyc(1, 1, 0, 0);
    cyc(1, 2, 0, 0);
    cyc(1, 3, 1, 0);
    pop_expect("R10 remaining first", 2);
    pop_expect("R10 new code behind", 3);
    chk("R10 count kept", int'(ne), 0);
  endtask

  task automatic t_clear;
    cyc(1, 11, 0, 0);
    cyc(1, 12, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R7 clear flag", int'(ne), 0);
    chk("R7 clear head", int'(head), 0);
    cyc(1, 13, 1, 1);
    chk("R7 clear wins over push", int'(ne), 0);
    cyc(1, 14, 0, 0);
    pop_expect("R7 usable after clear", 14);
    chk("R7 empty at end", int'(ne), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_empty_pop();
    t_overflow();
    t_full_swap();
    t_partial_swap();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule